// File: doc/BRIEF.md
# Sprite Attribute Block-Copy DMA Controller

This block fills the sprite attribute memory from a 256-byte source page without the processor taking part. Software writes a page number into the controller's page register, and that write queues a copy request. After a fixed one-machine-cycle delay the controller moves one byte in each machine cycle. It reads the source at `{page, index}` and writes the same `index` into attribute memory. The index starts at zero and counts up to the fixed transfer length minus one. It is a single hidden counter, and the same value addresses both the source and the target. Software cannot see this counter, cannot shorten the transfer and cannot stop it.

The source read goes to exactly one of two buses: the video RAM bus or the external bus. Pages in the video RAM window go to the video RAM bus. Every other page goes to the external bus, including the top two pages. As a result, a copy never reads back the attribute memory or the high register area.

While a copy runs, a busy flag is raised. A bus arbiter outside this block uses the flag to keep the processor off the buses involved. A new page write during a copy restarts the transfer from index zero with the new page. The flag stays high without a gap across the restart.

Top module: `oam_dma_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `oam_we` and `src_rd` are 0, and they stay 0 until a page write is accepted.
- R2: A page write is accepted when `reg_wr` and `mcycle_en` are both 1 on a clock edge; call that machine cycle M. Machine cycle M+1 performs no copy. The first byte is copied in machine cycle M+2.
- R3: Each transfer writes exactly 160 target addresses. They are written in ascending order 0x00, 0x01, …, 0x9F, so the index never reaches 0xA0. During the byte with index i, `src_addr` equals `{page, i}` and `oam_addr` equals i.
- R4: One byte is moved per machine cycle. `oam_we` is 1 only in clock cycles with `mcycle_en` = 1 during a copy, and in those cycles `oam_wdata` equals `src_rdata`.
- R5: `busy` rises in the first copy cycle and stays 1 through the cycle of the last byte (index 0x9F). It is 0 in the machine cycle that follows.
- R6: `src_sel` is 1 (video RAM bus) when the page is in 0x80–0x9F. It is 0 (external bus) for every other page, including 0x7F, 0xA0, 0xFE and 0xFF.
- R7: Suppose a page write is accepted in machine cycle M while a copy is running. Then M and M+1 still copy the next two bytes of the old page. M+2 copies index 0 of the new page, and a full 160-byte transfer of the new page follows. `busy` stays 1 throughout.
- R8: A `reg_wr` pulse in a clock cycle with `mcycle_en` = 0 is ignored, and no transfer starts. Between machine-cycle strobes, `oam_addr` and `busy` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcycle_en | input | 1 | One-clock strobe that marks the last clock of each machine cycle |
| reg_wr | input | 1 | Processor write to the page register |
| reg_wdata | input | 8 | Source page written by the processor |
| src_addr | output | 16 | Source read address {page, index} |
| src_sel | output | 1 | Source bus select: 1 for video RAM, 0 for external |
| src_rd | output | 1 | Source read request, held for each copy machine cycle |
| src_rdata | input | 8 | Read data returned by the selected source bus |
| oam_we | output | 1 | Attribute memory write strobe |
| oam_addr | output | 8 | Attribute memory write address (the hidden index) |
| oam_wdata | output | 8 | Attribute memory write data |
| busy | output | 1 | Copy in progress; the arbiter blocks processor accesses while it is 1 |

## Verification
The assertions assume that `mcycle_en` is a single-clock strobe with at least one idle clock between strobes. They also assume that `reg_wr` is held for only one clock, so each write is either accepted at one strobe or ignored. Finally, they assume that reset is held for at least one clock before the first strobe. The bench produces a strobe on every fourth clock and drives all inputs at falling edges. It issues page writes only in strobe cycles, except for the single off-strobe write that checks rejection. Source memory is modelled as a combinational function of the address and the selected bus, so returned data always matches the address in the same cycle.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

    localparam int PAGE_W = 8;
    localparam int LOW_W  = 8;
    localparam int ADDR_W = PAGE_W + LOW_W;

    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [LOW_W-1:0]  low_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        BUS_EXT  = 1'b0,
        BUS_VRAM = 1'b1
    } src_bus_e;

    typedef struct packed {
        logic  pend;
        page_t page;
    } dma_req_t;

    typedef struct packed {
        logic  active;
        page_t page;
        low_t  low;
    } dma_cursor_t;

    function automatic src_bus_e bus_for_page(page_t p, page_t first, page_t last);
        return ((p >= first) && (p <= last)) ? BUS_VRAM : BUS_EXT;
    endfunction

endpackage

// File: rtl/oam_dma_req.sv
module oam_dma_req
    import oam_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mcycle_en,
    input  logic     reg_wr,
    input  page_t    reg_wdata,
    output dma_req_t req
);

    dma_req_t req_q;

    // An accepted write is held for exactly one machine cycle (the delay cycle).
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (mcycle_en) begin
            req_q.pend <= reg_wr;
            if (reg_wr) begin
                req_q.page <= reg_wdata;
            end
        end
    end

    assign req = req_q;

endmodule

// File: rtl/oam_dma_seq.sv
module oam_dma_seq
    import oam_dma_pkg::*;
#(
    parameter int XFER_LEN = 160
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mcycle_en,
    input  dma_req_t    req,
    output dma_cursor_t cur
);

    localparam low_t LAST_LOW = low_t'(XFER_LEN - 1);

    dma_cursor_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (mcycle_en) begin
            if (req.pend) begin
                // a pending request always wins, restarting any running copy
                cur_q.active <= 1'b1;
                cur_q.page   <= req.page;
                cur_q.low    <= '0;
            end else if (cur_q.active) begin
                if (cur_q.low == LAST_LOW) begin
                    cur_q.active <= 1'b0;
                    cur_q.low    <= '0;
                end else begin
                    cur_q.low <= cur_q.low + low_t'(1);
                end
            end
        end
    end

    assign cur = cur_q;

endmodule

// File: rtl/oam_dma_route.sv
module oam_dma_route
    import oam_dma_pkg::*;
#(
    parameter page_t VRAM_FIRST = 8'h80,
    parameter page_t VRAM_LAST  = 8'h9F
) (
    input  dma_cursor_t cur,
    input  logic        mcycle_en,
    input  logic [7:0]  src_rdata,
    output addr_t       src_addr,
    output logic        src_sel,
    output logic        src_rd,
    output logic        oam_we,
    output low_t        oam_addr,
    output logic [7:0]  oam_wdata
);

    src_bus_e bus;

    always_comb begin
        bus       = bus_for_page(cur.page, VRAM_FIRST, VRAM_LAST);
        src_addr  = {cur.page, cur.low};
        src_sel   = (bus == BUS_VRAM);
        src_rd    = cur.active;
        oam_addr  = cur.low;
        oam_wdata = src_rdata;
        oam_we    = cur.active & mcycle_en;
    end

endmodule

// File: rtl/oam_dma_ctrl.sv
module oam_dma_ctrl
    import oam_dma_pkg::*;
#(
    parameter int    XFER_LEN   = 160,
    parameter page_t VRAM_FIRST = 8'h80,
    parameter page_t VRAM_LAST  = 8'h9F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mcycle_en,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] src_addr,
    output logic        src_sel,
    output logic        src_rd,
    input  logic [7:0]  src_rdata,
    output logic        oam_we,
    output logic [7:0]  oam_addr,
    output logic [7:0]  oam_wdata,
    output logic        busy
);

    dma_req_t    req;
    dma_cursor_t cur;

    oam_dma_req u_req (
        .clk       (clk),
        .rst       (rst),
        .mcycle_en (mcycle_en),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .req       (req)
    );

    oam_dma_seq #(.XFER_LEN(XFER_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mcycle_en (mcycle_en),
        .req       (req),
        .cur       (cur)
    );

    oam_dma_route #(.VRAM_FIRST(VRAM_FIRST), .VRAM_LAST(VRAM_LAST)) u_route (
        .cur       (cur),
        .mcycle_en (mcycle_en),
        .src_rdata (src_rdata),
        .src_addr  (src_addr),
        .src_sel   (src_sel),
        .src_rd    (src_rd),
        .oam_we    (oam_we),
        .oam_addr  (oam_addr),
        .oam_wdata (oam_wdata)
    );

    assign busy = cur.active;

endmodule

// File: rtl/oam_dma_chk.sv
module oam_dma_chk #(
    parameter int XFER_LEN = 160
) (
    input logic        clk,
    input logic        rst,
    input logic        mcycle_en,
    input logic        reg_wr,
    input logic        busy,
    input logic        oam_we,
    input logic [7:0]  oam_addr,
    input logic [15:0] src_addr,
    input logic        src_sel
);

    logic [7:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= 8'd0;
        end else if (oam_we) begin
            last_addr <= oam_addr;
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !oam_we));

    assert_no_same_cycle_start_R2: assert property (@(posedge clk) disable iff (rst)
        (mcycle_en && reg_wr && !busy) |=> !busy);

    assert_first_index_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (oam_addr == 8'd0));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (oam_we && oam_addr != 8'd0) |-> (oam_addr == 8'(last_addr + 8'd1)));

    assert_index_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (oam_addr < 8'(XFER_LEN)));

    assert_full_length_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (last_addr == 8'(XFER_LEN - 1)));

    assert_top_pages_external_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && src_addr[15:9] == 7'h7F) |-> !src_sel);

    assert_video_window_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && src_addr[15:13] == 3'b100) |-> src_sel);

    assert_hold_between_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        !mcycle_en |=> ($stable(oam_addr) && $stable(busy)));

endmodule

bind oam_dma_ctrl oam_dma_chk #(.XFER_LEN(XFER_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mcycle_en (mcycle_en),
    .reg_wr    (reg_wr),
    .busy      (busy),
    .oam_we    (oam_we),
    .oam_addr  (oam_addr),
    .src_addr  (src_addr),
    .src_sel   (src_sel)
);

// File: tb/oam_dma_ctrl_bench.sv
`timescale 1ns/1ps
module oam_dma_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 160;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mcycle_en;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [15:0] src_addr;
    logic        src_sel;
    logic        src_rd;
    logic [7:0]  src_rdata;
    logic        oam_we;
    logic [7:0]  oam_addr;
    logic [7:0]  oam_wdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0] phase = 2'd0;
    logic [7:0] oam_img [0:255];
    logic [7:0] log_a   [0:511];
    int         log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) phase <= phase + 2'd1;
    assign mcycle_en = (phase == 2'd3);

    function automatic logic [7:0] pat(logic [15:0] a, logic sel);
        return 8'(a[7:0] * 8'd3) ^ a[15:8] ^ (sel ? 8'hC3 : 8'h00);
    endfunction

    function automatic logic exp_sel(logic [7:0] p);
        return (p >= 8'h80) && (p <= 8'h9F);
    endfunction

    assign src_rdata = pat(src_addr, src_sel);

    oam_dma_ctrl u_oam_dma_ctrl (
        .clk(clk), .rst(rst), .mcycle_en(mcycle_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .src_addr(src_addr), .src_sel(src_sel), .src_rd(src_rd),
        .src_rdata(src_rdata), .oam_we(oam_we), .oam_addr(oam_addr),
        .oam_wdata(oam_wdata), .busy(busy)
    );

    always @(posedge clk) begin
        if (!rst && oam_we) begin
            oam_img[oam_addr] = oam_wdata;
            if (log_n < 512) log_a[log_n] = oam_addr;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_mc();
        do @(negedge clk); while (!mcycle_en);
    endtask

    task automatic cpu_write(input logic [7:0] page);
        wait_mc();
        reg_wr    = 1'b1;
        reg_wdata = page;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // called at the falling edge of a strobe cycle
    task automatic check_byte(input logic [7:0] page, input int idx, input string req);
        logic [15:0] ea;
        logic        es;
        logic        ok;
        ea = {page, 8'(idx)};
        es = exp_sel(page);
        ok = busy && oam_we && src_rd && (oam_addr == 8'(idx)) && (src_addr == ea)
             && (src_sel == es) && (oam_wdata == pat(ea, es));
        check(ok, req, {busy, oam_we, src_sel, 5'd0, src_addr, oam_wdata},
              {1'b1, 1'b1, es, 5'd0, ea, pat(ea, es)});
    endtask

    task automatic test_reset();
        wait_mc();
        check(!busy && !oam_we && !src_rd, "R1 idle after reset",
              {29'd0, busy, oam_we, src_rd}, 32'd0);
    endtask

    task automatic run_full(input logic [7:0] page);
        bit asc;
        bit img_ok;
        log_n = 0;
        cpu_write(page);
        wait_mc();
        check(!busy && !oam_we, "R2 no copy in delay cycle",
              {30'd0, busy, oam_we}, 32'd0);
        for (int i = 0; i < LEN; i++) begin
            wait_mc();
            check_byte(page, i, (i == 0) ? "R2 first byte at M+2" : "R3 R4 R6 copy byte");
            if (i == 10) begin
                @(negedge clk);
                check(busy && !oam_we, "R4 R5 no write between strobes",
                      {30'd0, busy, oam_we}, {30'd0, 2'b10});
            end
        end
        wait_mc();
        check(!busy && !oam_we, "R5 busy low after last byte",
              {30'd0, busy, oam_we}, 32'd0);
        asc = 1'b1;
        for (int i = 0; i < LEN; i++) if (log_a[i] != 8'(i)) asc = 1'b0;
        check((log_n == LEN) && asc, "R3 160 ascending writes", 32'(log_n), 32'(LEN));
        img_ok = 1'b1;
        for (int i = 0; i < LEN; i++)
            if (oam_img[i] != pat({page, 8'(i)}, exp_sel(page))) img_ok = 1'b0;
        check(img_ok, "R3 R6 attribute image matches source", {31'd0, img_ok}, 32'd1);
    endtask

    task automatic test_ignored();
        wait_mc();
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = 8'h12;
        @(negedge clk);
        reg_wr    = 1'b0;
        for (int k = 0; k < 3; k++) begin
            wait_mc();
            check(!busy && !oam_we, "R8 off-strobe write ignored",
                  {30'd0, busy, oam_we}, 32'd0);
        end
    endtask

    task automatic test_restart(input logic [7:0] pa, input logic [7:0] pb);
        log_n = 0;
        cpu_write(pa);
        wait_mc();
        for (int i = 0; i <= 50; i++) begin
            wait_mc();
            check_byte(pa, i, "R7 old page before restart");
        end
        reg_wr    = 1'b1;
        reg_wdata = pb;
        @(negedge clk);
        reg_wr    = 1'b0;
        wait_mc();
        check_byte(pa, 51, "R7 old page continues in delay cycle");
        for (int i = 0; i < LEN; i++) begin
            wait_mc();
            check_byte(pb, i, "R7 new page after restart");
        end
        wait_mc();
        check(!busy, "R7 busy low after restarted copy", {31'd0, busy}, 32'd0);
        check(log_n == 52 + LEN, "R7 write count", 32'(log_n), 32'(52 + LEN));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_ignored();
        run_full(8'hC0);
        run_full(8'h80);
        run_full(8'h9F);
        run_full(8'hA0);
        run_full(8'h7F);
        run_full(8'hFE);
        run_full(8'hFF);
        test_restart(8'hC1, 8'h85);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule